// File: doc/BRIEF.md
# Tile Sleep-Switch Control Selector

This block holds the run-time sleep control for a row of logic tiles. Every tile has a small set of input pins, and configuration can pick one of them to act as the tile's power control signal instead of an ordinary logic input. From that signal, the block derives two switch enables for each tile. One is for the tile's logic cluster. The other is for the routing channel on the tile's left side. Each enable can be fixed on, fixed off, or made to follow the control signal.

Two neighbouring tiles share a routing channel. When that channel follows control, it stays powered while either neighbour asks for power. A channel that carries a control pin into a tile is always held powered, because gating it would cut the tile off from its own wake-up signal. The block also reports which pins were taken for power control, and it passes the remaining pins to the tile logic with the taken pin masked.

Configuration is written through a serial shift chain. New settings take effect together, once the shift enable is dropped, so the enables never show a half-loaded configuration.

Top module: `pg_tile_ctrl`

## Requirements
- R1: After reset every cluster enable and every channel enable is 1. No pin is marked taken, and logic_in equals pin_in.
- R2: While cfg_en is 1, each rising edge shifts cfg_sdi into bit 0 of a TILES*7-bit chain, and cfg_sdo shows the chain's top bit. A bit therefore reaches cfg_sdo TILES*7 shifts after it entered. Tile t occupies bits [7t+6:7t]: pin select in [7t+6:7t+4], cluster mode in [7t+3:7t+2], channel mode in [7t+1:7t].
- R3: The shifted chain becomes the active configuration at the first rising edge where cfg_en is 0 after being 1. While shifting, all enables keep following the previous configuration.
- R4: A pin select below PINS (4) makes tile t's control equal to pin_in[t*PINS+select]. Any larger select means the tile has no control pin, and its control reads as 1. Control 1 requests power.
- R5: pin_taken has exactly the selected pin set for each tile, or nothing when there is no selection. logic_in is pin_in with the taken pins forced to 0.
- R6: Cluster mode encoding: 00 gives clu_en 0, 01 gives 1, 10 makes clu_en follow the tile's control, and the reserved value 11 gives 1.
- R7: Channel mode uses the same encoding. In mode 10, channel k (left of tile k) is on when the control of tile k or tile k-1 is 1. Channel 0 follows tile 0 alone.
- R8: Channel k is forced on whatever its mode in two cases: tile k has selected an even-numbered pin (fed from its left channel), or tile k-1 has selected an odd-numbered pin (fed from its right channel, which is channel k). An odd pin on the last tile enters from outside the row and forces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_sdo | output | 1 | Serial configuration data out (chain top bit) |
| pin_in | input | TILES*PINS | Input connection outputs, tile t at [t*PINS +: PINS] |
| clu_en | output | TILES | Cluster sleep-switch enables, 1 = powered |
| chn_en | output | TILES | Routing-channel sleep-switch enables, 1 = powered |
| pin_taken | output | TILES*PINS | Pins claimed as power control |
| logic_in | output | TILES*PINS | Pins delivered to tile logic, taken pins masked to 0 |

## Verification
The enables, pin_taken and logic_in are combinational from pin_in and the active configuration. They are due in the same cycle as a pin change, so the bench changes pins on a falling edge and checks a little later, within that half period. A new configuration is due one rising edge after cfg_en drops. The bench drops cfg_en on a falling edge, waits for the next falling edge and then checks. cfg_sdo moves one bit per shifting edge, so it is compared against the previously loaded vector just before each edge. Enables are sampled halfway through a load to show that they do not move.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        PGM_OFF = 2'b00,
        PGM_ON  = 2'b01,
        PGM_DYN = 2'b10,
        PGM_RSV = 2'b11
    } pgc_mode_e;

    localparam int PGC_MODE_W = 2;

    // Switch enable for a given mode; reserved code falls back to powered
    function automatic logic mode_enable(input pgc_mode_e mode, input logic dyn_req);
        logic en;
        case (mode)
            PGM_OFF: en = 1'b0;
            PGM_DYN: en = dyn_req;
            default: en = 1'b1;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/pgc_cfg_chain.sv
module pgc_cfg_chain
    import pgc_pkg::*;
#(
    parameter int TILES  = 4,
    parameter int PINS   = 4,
    parameter int SEL_W  = $clog2(PINS + 1),
    parameter int WORD_W = SEL_W + 2 * PGC_MODE_W,
    parameter int TOT_W  = TILES * WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_sdi,
    output logic             cfg_sdo,
    output logic [TOT_W-1:0] active_cfg
);

    localparam logic [WORD_W-1:0] RST_WORD = {SEL_W'(PINS), PGM_ON, PGM_ON};
    localparam logic [TOT_W-1:0]  RST_VEC  = {TILES{RST_WORD}};

    logic [TOT_W-1:0] shift_q;
    logic [TOT_W-1:0] active_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q  <= RST_VEC;
            active_q <= RST_VEC;
            en_q     <= 1'b0;
        end else begin
            en_q <= cfg_en;
            if (cfg_en) begin
                shift_q <= {shift_q[TOT_W-2:0], cfg_sdi};
            end
            if (en_q && !cfg_en) begin
                active_q <= shift_q;
            end
        end
    end

    assign cfg_sdo    = shift_q[TOT_W-1];
    assign active_cfg = active_q;

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable(active_q));

endmodule

// File: rtl/pgc_tile.sv
module pgc_tile
    import pgc_pkg::*;
#(
    parameter int PINS  = 4,
    parameter int SEL_W = $clog2(PINS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PINS-1:0]  pins,
    input  logic [SEL_W-1:0] sel,
    input  pgc_mode_e        clu_mode,
    output logic             ctrl,
    output logic             clu_en,
    output logic [PINS-1:0]  taken,
    output logic [PINS-1:0]  logic_pins,
    output logic             entry_left,
    output logic             entry_right
);

    logic sel_ok;

    assign sel_ok = (sel < SEL_W'(PINS));

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign taken[p] = sel_ok && (sel == SEL_W'(p));
    end

    assign ctrl        = sel_ok ? |(pins & taken) : 1'b1;
    assign logic_pins  = pins & ~taken;
    assign entry_left  = sel_ok && !sel[0];
    assign entry_right = sel_ok && sel[0];
    assign clu_en      = mode_enable(clu_mode, ctrl);

    // R5
    taken_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(taken));

    // R4
    no_sel_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_ok) |-> (ctrl && taken == '0));

    // R6
    clu_off_chk: assert property (@(posedge clk) disable iff (rst)
        (clu_mode == PGM_OFF) |-> !clu_en);

    // R6
    clu_on_chk: assert property (@(posedge clk) disable iff (rst)
        (clu_mode == PGM_ON || clu_mode == PGM_RSV) |-> clu_en);

endmodule

// File: rtl/pgc_chan.sv
module pgc_chan
    import pgc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pgc_mode_e mode,
    input  logic      ctrl_a,
    input  logic      ctrl_b,
    input  logic      force_on,
    output logic      en
);

    assign en = force_on | mode_enable(mode, ctrl_a | ctrl_b);

    // R8
    entry_forced_chk: assert property (@(posedge clk) disable iff (rst)
        force_on |-> en);

    // R7
    both_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PGM_DYN && !force_on && !ctrl_a && !ctrl_b) |-> !en);

endmodule

// File: rtl/pg_tile_ctrl.sv
module pg_tile_ctrl
    import pgc_pkg::*;
#(
    parameter int TILES = 4,
    parameter int PINS  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_en,
    input  logic                  cfg_sdi,
    output logic                  cfg_sdo,
    input  logic [TILES*PINS-1:0] pin_in,
    output logic [TILES-1:0]      clu_en,
    output logic [TILES-1:0]      chn_en,
    output logic [TILES*PINS-1:0] pin_taken,
    output logic [TILES*PINS-1:0] logic_in
);

    localparam int SEL_W  = $clog2(PINS + 1);
    localparam int WORD_W = SEL_W + 2 * PGC_MODE_W;
    localparam int TOT_W  = TILES * WORD_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        pgc_mode_e        clu_mode;
        pgc_mode_e        chn_mode;
    } tile_cfg_t;

    logic [TOT_W-1:0] active_cfg;
    tile_cfg_t        tcfg   [TILES];
    logic [TILES-1:0] ctrl;
    logic [TILES-1:0] ent_l;
    logic [TILES-1:0] ent_r;

    pgc_cfg_chain #(
        .TILES (TILES),
        .PINS  (PINS),
        .SEL_W (SEL_W),
        .WORD_W(WORD_W),
        .TOT_W (TOT_W)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_en),
        .cfg_sdi   (cfg_sdi),
        .cfg_sdo   (cfg_sdo),
        .active_cfg(active_cfg)
    );

    for (genvar t = 0; t < TILES; t++) begin : g_tile
        assign tcfg[t] = tile_cfg_t'(active_cfg[t*WORD_W +: WORD_W]);

        pgc_tile #(
            .PINS (PINS),
            .SEL_W(SEL_W)
        ) u_tile (
            .clk        (clk),
            .rst        (rst),
            .pins       (pin_in[t*PINS +: PINS]),
            .sel        (tcfg[t].sel),
            .clu_mode   (tcfg[t].clu_mode),
            .ctrl       (ctrl[t]),
            .clu_en     (clu_en[t]),
            .taken      (pin_taken[t*PINS +: PINS]),
            .logic_pins (logic_in[t*PINS +: PINS]),
            .entry_left (ent_l[t]),
            .entry_right(ent_r[t])
        );
    end

    for (genvar k = 0; k < TILES; k++) begin : g_chan
        logic nb_ctrl;
        logic nb_entry;
        if (k == 0) begin : g_edge
            assign nb_ctrl  = 1'b0;
            assign nb_entry = 1'b0;
        end else begin : g_inner
            assign nb_ctrl  = ctrl[k-1];
            assign nb_entry = ent_r[k-1];
        end

        pgc_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .mode    (tcfg[k].chn_mode),
            .ctrl_a  (ctrl[k]),
            .ctrl_b  (nb_ctrl),
            .force_on(ent_l[k] | nb_entry),
            .en      (chn_en[k])
        );
    end

    // R1
    reset_release_chk: assert property (@(posedge clk)
        $fell(rst) |-> (clu_en == '1 && chn_en == '1 && pin_taken == '0));

endmodule

// File: tb/pg_tile_ctrl_bench.sv
`timescale 1ns/1ps
module pg_tile_ctrl_bench;

    localparam int N  = 4;
    localparam int P  = 4;
    localparam int SW = 3;
    localparam int WW = 7;
    localparam int TW = N * WW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_en = 1'b0;
    logic          cfg_sdi = 1'b0;
    logic          cfg_sdo;
    logic [N*P-1:0] pin_in = '0;
    logic [N-1:0]  clu_en, chn_en;
    logic [N*P-1:0] pin_taken, logic_in;

    int checks = 0;
    int failures = 0;

    logic [SW-1:0] b_sel [N];
    logic [1:0]    b_cm  [N];
    logic [1:0]    b_chm [N];
    logic [TW-1:0] last_vec;

    always #5 clk = ~clk;

    pg_tile_ctrl #(.TILES(N), .PINS(P)) u_pg_tile_ctrl (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sdi(cfg_sdi),
        .cfg_sdo(cfg_sdo), .pin_in(pin_in), .clu_en(clu_en),
        .chn_en(chn_en), .pin_taken(pin_taken), .logic_in(logic_in)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] pack_cfg();
        logic [TW-1:0] v;
        for (int t = 0; t < N; t++) v[t*WW +: WW] = {b_sel[t], b_cm[t], b_chm[t]};
        return v;
    endfunction

    function automatic logic men(input logic [1:0] m, input logic d);
        return (m == 2'b00) ? 1'b0 : (m == 2'b10) ? d : 1'b1;
    endfunction

    task automatic model(output logic [N-1:0] eclu, output logic [N-1:0] echn,
                         output logic [N*P-1:0] etk);
        logic [N-1:0] c;
        logic frc;
        etk = '0;
        for (int t = 0; t < N; t++) begin
            if (b_sel[t] < P) begin
                c[t] = pin_in[t*P + int'(b_sel[t])];
                etk[t*P + int'(b_sel[t])] = 1'b1;
            end else c[t] = 1'b1;
            eclu[t] = men(b_cm[t], c[t]);
        end
        for (int k = 0; k < N; k++) begin
            frc = (b_sel[k] < P) && !b_sel[k][0];
            if (k > 0) frc = frc || ((b_sel[k-1] < P) && b_sel[k-1][0]);
            echn[k] = frc ? 1'b1 : men(b_chm[k], c[k] | ((k > 0) ? c[k-1] : 1'b0));
        end
    endtask

    task automatic check_all(input string req);
        logic [N-1:0] eclu, echn;
        logic [N*P-1:0] etk;
        model(eclu, echn, etk);
        chk({req, " clu_en"}, 64'(clu_en), 64'(eclu));
        chk({req, " chn_en"}, 64'(chn_en), 64'(echn));
        chk({req, " pin_taken"}, 64'(pin_taken), 64'(etk));
        chk({req, " logic_in"}, 64'(logic_in), 64'(pin_in & ~etk));
    endtask

    // Shift the arrays' packed form in MSB first; checks R2 and R3 on the way
    task automatic load_cfg();
        logic [TW-1:0] v;
        logic [N-1:0]  clu0, chn0;
        v = pack_cfg();
        @(negedge clk);
        clu0 = clu_en;
        chn0 = chn_en;
        for (int i = 0; i < TW; i++) begin
            cfg_en  = 1'b1;
            cfg_sdi = v[TW-1-i];
            #1;
            if (i == 0 || i == TW / 2 || i == TW - 1)
                chk("R2 sdo", 64'(cfg_sdo), 64'(last_vec[TW-1-i]));
            if (i == TW / 2) begin
                chk("R3 clu hold", 64'(clu_en), 64'(clu0));
                chk("R3 chn hold", 64'(chn_en), 64'(chn0));
            end
            @(negedge clk);
        end
        cfg_en = 1'b0;
        @(negedge clk);
        #1;
        last_vec = v;
    endtask

    task automatic t_reset();
        pin_in = 16'hA5C3;
        #1;
        chk("R1 clu_en", 64'(clu_en), 64'hF);
        chk("R1 chn_en", 64'(chn_en), 64'hF);
        chk("R1 pin_taken", 64'(pin_taken), 64'h0);
        chk("R1 logic_in", 64'(logic_in), 64'hA5C3);
    endtask

    task automatic t_static();
        b_cm  = '{2'b00, 2'b01, 2'b11, 2'b00};
        b_chm = '{2'b00, 2'b11, 2'b00, 2'b01};
        for (int t = 0; t < N; t++) b_sel[t] = 3'd4;
        load_cfg();
        chk("R6 static clu", 64'(clu_en), 64'b0110);
        chk("R7 static chn", 64'(chn_en), 64'b1010);
        pin_in = 16'h0000;
        #1;
        chk("R6 static clu pins low", 64'(clu_en), 64'b0110);
        check_all("R3 committed");
    endtask

    task automatic t_dyn_cluster();
        b_cm  = '{2'b10, 2'b10, 2'b10, 2'b10};
        b_chm = '{2'b01, 2'b01, 2'b01, 2'b01};
        b_sel = '{3'd0, 3'd1, 3'd2, 3'd3};
        load_cfg();
        foreach (b_sel[i]) begin end
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            pin_in = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF :
                     (p == 2) ? 16'h8421 : 16'h7BDE;
            #1;
            check_all("R4 R5 R6 dyn");
        end
        chk("R4 pattern 7BDE", 64'(clu_en), 64'b0000);
        chk("R5 taken", 64'(pin_taken), 64'h8421);
        b_sel = '{3'd5, 3'd1, 3'd7, 3'd3};
        load_cfg();
        pin_in = 16'h0000;
        #1;
        chk("R4 no select", 64'(clu_en), 64'b0101);
        chk("R5 no select taken", 64'(pin_taken), 64'h0020 | 64'h8000);
    endtask

    task automatic t_chan();
        b_cm  = '{2'b00, 2'b00, 2'b00, 2'b00};
        b_chm = '{2'b10, 2'b10, 2'b10, 2'b10};
        b_sel = '{3'd1, 3'd0, 3'd1, 3'd3};
        load_cfg();
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            pin_in = '0;
            pin_in[4] = p[0];
            pin_in[9] = p[1];
            pin_in[1] = p[0];
            #1;
            chk("R7 shared channel", 64'(chn_en[2]), 64'(p[0] | p[1]));
            chk("R7 edge channel", 64'(chn_en[0]), 64'(p[0]));
            check_all("R7 dyn chan");
        end
    endtask

    task automatic t_force();
        b_cm  = '{2'b01, 2'b01, 2'b01, 2'b01};
        b_chm = '{2'b00, 2'b00, 2'b00, 2'b00};
        b_sel = '{3'd2, 3'd3, 3'd4, 3'd4};
        load_cfg();
        pin_in = 16'h0000;
        #1;
        chk("R8 forced off-mode", 64'(chn_en), 64'b0101);
        b_sel = '{3'd4, 3'd4, 3'd4, 3'd1};
        load_cfg();
        chk("R8 last tile right pin", 64'(chn_en), 64'b0000);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        last_vec = {N{{3'd4, 2'b01, 2'b01}}};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_static();
        t_dyn_cluster();
        t_chan();
        t_force();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule